// File: doc/BRIEF.md
# Indirect Management Register Access Engine

This block is a host-side sequencer that reaches the registers of a managed device over a management bus. A requester asks for one read or one write by giving a device address, a register number and, for writes, a 16-bit data word. The sequencer turns that request into one or more transactions on an abstract bus port. Each bus transaction carries direction, bus address, register number and data. The bus answers it with a one-cycle completion that carries read data and an error flag. Serial bit timing on the wire is handled elsewhere.

The `base_addr` input is sampled when a request is taken and selects the mode. If it is zero, the device decodes every bus address directly, and the request becomes a single bus transaction at the requested device address and register. If it is non-zero, the device answers only at that one address and exposes two slots there: slot 0 is the command register and slot 1 is the data register. The sequencer then polls a busy flag, moves data through slot 1, issues a command word through slot 0 and polls the busy flag again. Busy polling is bounded by a retry count. A bus error ends the sequence at once.

The controller has eight states. `ST_IDLE` waits for a request; an accepted request goes to `ST_DIRECT` when the base is zero and to `ST_WAIT_FREE` otherwise. `ST_DIRECT` goes to `ST_RESPOND` on completion. `ST_WAIT_FREE` stays while the busy flag is set and retries remain. Once the flag is clear it goes to `ST_PUT_DATA` for a write and to `ST_PUT_CMD` for a read. `ST_PUT_DATA` goes to `ST_PUT_CMD`, and `ST_PUT_CMD` goes to `ST_WAIT_CMD`. `ST_WAIT_CMD` polls like `ST_WAIT_FREE`. When the flag clears it goes to `ST_GET_DATA` for a read and to `ST_RESPOND` for a write. `ST_GET_DATA` goes to `ST_RESPOND`. Any bus error, or a retry budget used up in either wait state, goes straight to `ST_RESPOND`. `ST_RESPOND` lasts one cycle and returns to `ST_IDLE`.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: Direct mode (zero `base_addr` when the request is taken). The request becomes exactly one bus transaction at `req_dev`/`req_reg` with the request's direction and write data. For a read, `rsp_rdata` returns that transaction's read data.
- R2: Indirect mode (non-zero base). Every bus transaction goes to the base address. Register 0 is the command slot and register 1 is the data slot.
- R3: The command word is `16'h9800 | (dev << 5) | reg` for a read and `16'h9400 | (dev << 5) | reg` for a write.
- R4: Bit 15 of a command-slot read is the busy flag; the other bits are ignored. In indirect mode the command slot is read until busy is clear, both before the command is issued and after it.
- R5: If 16 consecutive busy polls all show bit 15 set, the sequence ends with no further bus transaction. `rsp_timeout` is then 1, `rsp_buserr` is 0 and `rsp_rdata` is 0.
- R6: An indirect write sends the data to slot 1 first and then the write command to slot 0, followed by the post-command poll.
- R7: An indirect read sends the read command, polls until busy clears, then reads slot 1. That 16-bit value is returned on `rsp_rdata`.
- R8: A bus completion with `bus_err` set ends the sequence at once: that transaction is the last one. `rsp_buserr` is then 1, `rsp_timeout` is 0 and `rsp_rdata` is 0.
- R9: A request is taken only in `ST_IDLE`, which is shown by `req_ready`. A `req_valid` pulse while busy has no effect on the bus sequence and produces no extra response.
- R10: `rsp_done` is a single-cycle pulse. `rsp_rdata`, `rsp_timeout` and `rsp_buserr` are valid in that cycle. After a write, or after any failed sequence, `rsp_rdata` is 0.
- R11: After reset, `req_ready` is 1 and `bus_valid` and `rsp_done` are 0.
- R12: While `bus_valid` is high and `bus_done` has not arrived, `bus_write`, `bus_addr`, `bus_reg` and `bus_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | ADDR_W | Device base address; zero selects direct mode |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | ADDR_W | Target device address |
| req_reg | input | REG_W | Target register number |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle, a request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_timeout | output | 1 | Busy polling exhausted |
| rsp_buserr | output | 1 | A bus transaction reported an error |
| bus_valid | output | 1 | Bus transaction pending |
| bus_write | output | 1 | Bus transaction direction |
| bus_addr | output | ADDR_W | Bus address |
| bus_reg | output | REG_W | Bus register number |
| bus_wdata | output | 16 | Bus write data |
| bus_done | input | 1 | Bus transaction complete |
| bus_rdata | input | 16 | Bus read data, valid with `bus_done` |
| bus_err | input | 1 | Bus transaction failed, valid with `bus_done` |

## Verification
Each request in the bench records the full bus transaction log and compares it with a sequence computed from the requirements. The requests mix direct and indirect mode, reads and writes, and random device and register fields. This separates a wrong command word from a wrong slot, and a wrong order of data and command. Busy-poll counts of 0, 15, 16 and more, placed before or after the command, separate the last successful poll from the timeout boundary in each wait state. The model returns 16'h7FFF for an idle command slot, so a design that looks at any bit other than bit 15 is caught. Errors injected at a random transaction index, and a request strobe raised mid-sequence, show whether the sequence stops at the faulty transaction and whether a busy sequencer takes nothing new.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;

    // Width of a management bus data word
    localparam int MGMT_DW = 16;

    // Busy flag position in the command slot
    localparam int BUSY_BIT = 15;

    // Slot numbers inside the device window in indirect mode
    localparam int CMD_SLOT  = 0;
    localparam int DATA_SLOT = 1;

    // Command word prefixes: start bit, mode bit and opcode field
    localparam logic [MGMT_DW-1:0] CMD_RD_PREFIX = 16'h9800;
    localparam logic [MGMT_DW-1:0] CMD_WR_PREFIX = 16'h9400;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIRECT,
        ST_WAIT_FREE,
        ST_PUT_DATA,
        ST_PUT_CMD,
        ST_WAIT_CMD,
        ST_GET_DATA,
        ST_RESPOND
    } seq_state_t;

endpackage

// File: rtl/mgmt_cmd_word.sv
module mgmt_cmd_word
    import mgmt_seq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int REG_W  = 5
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] dev,
    input  logic [REG_W-1:0]  regn,
    output logic [MGMT_DW-1:0] word
);

    // Device field sits directly above the register field
    localparam int DEV_LSB = REG_W;

    logic [MGMT_DW-1:0] prefix;
    logic [MGMT_DW-1:0] dev_field;
    logic [MGMT_DW-1:0] reg_field;

    always_comb begin
        prefix    = is_write ? CMD_WR_PREFIX : CMD_RD_PREFIX;
        dev_field = MGMT_DW'(dev) << DEV_LSB;
        reg_field = MGMT_DW'(regn);
        word      = prefix | dev_field | reg_field;
    end

endmodule

// File: rtl/mgmt_poll_ctr.sv
module mgmt_poll_ctr #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == LAST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq
    import mgmt_seq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int REG_W     = 5,
    parameter int MAX_POLLS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_dev,
    input  logic [REG_W-1:0]   req_reg,
    input  logic [MGMT_DW-1:0] req_wdata,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [MGMT_DW-1:0] rsp_rdata,
    output logic               rsp_timeout,
    output logic               rsp_buserr,
    output logic               bus_valid,
    output logic               bus_write,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [REG_W-1:0]   bus_reg,
    output logic [MGMT_DW-1:0] bus_wdata,
    input  logic               bus_done,
    input  logic [MGMT_DW-1:0] bus_rdata,
    input  logic               bus_err
);

    localparam logic [REG_W-1:0] CMD_REG  = REG_W'(CMD_SLOT);
    localparam logic [REG_W-1:0] DATA_REG = REG_W'(DATA_SLOT);

    seq_state_t state_q, state_d;

    logic               op_wr_q;
    logic [ADDR_W-1:0]  dev_q;
    logic [REG_W-1:0]   reg_q;
    logic [MGMT_DW-1:0] wdata_q;
    logic [ADDR_W-1:0]  base_q;
    logic [MGMT_DW-1:0] rdata_q;
    logic               tmo_q;
    logic               err_q;

    logic               accept;
    logic               xfer_ok;
    logic               xfer_bad;
    logic               polling;
    logic               busy_seen;
    logic               poll_last;
    logic               poll_clr;
    logic               poll_inc;
    logic               poll_giveup;
    logic [MGMT_DW-1:0] cmd_word;

    assign accept      = req_valid && (state_q == ST_IDLE);
    assign xfer_ok     = bus_valid && bus_done && !bus_err;
    assign xfer_bad    = bus_valid && bus_done && bus_err;
    assign polling     = (state_q == ST_WAIT_FREE) || (state_q == ST_WAIT_CMD);
    assign busy_seen   = bus_rdata[BUSY_BIT];
    assign poll_clr    = !polling;
    assign poll_inc    = polling && xfer_ok && busy_seen;
    assign poll_giveup = poll_inc && poll_last;

    mgmt_cmd_word #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_cmd (
        .is_write (op_wr_q),
        .dev      (dev_q),
        .regn     (reg_q),
        .word     (cmd_word)
    );

    mgmt_poll_ctr #(
        .MAX_POLLS (MAX_POLLS)
    ) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (base_addr == '0) ? ST_DIRECT : ST_WAIT_FREE;
                end
            end
            ST_DIRECT: begin
                if (xfer_bad || xfer_ok) begin
                    state_d = ST_RESPOND;
                end
            end
            ST_WAIT_FREE: begin
                if (xfer_bad || poll_giveup) begin
                    state_d = ST_RESPOND;
                end else if (xfer_ok && !busy_seen) begin
                    state_d = op_wr_q ? ST_PUT_DATA : ST_PUT_CMD;
                end
            end
            ST_PUT_DATA: begin
                if (xfer_bad) begin
                    state_d = ST_RESPOND;
                end else if (xfer_ok) begin
                    state_d = ST_PUT_CMD;
                end
            end
            ST_PUT_CMD: begin
                if (xfer_bad) begin
                    state_d = ST_RESPOND;
                end else if (xfer_ok) begin
                    state_d = ST_WAIT_CMD;
                end
            end
            ST_WAIT_CMD: begin
                if (xfer_bad || poll_giveup) begin
                    state_d = ST_RESPOND;
                end else if (xfer_ok && !busy_seen) begin
                    state_d = op_wr_q ? ST_RESPOND : ST_GET_DATA;
                end
            end
            ST_GET_DATA: begin
                if (xfer_bad || xfer_ok) begin
                    state_d = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Request capture and result collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
            dev_q   <= '0;
            reg_q   <= '0;
            wdata_q <= '0;
            base_q  <= '0;
            rdata_q <= '0;
            tmo_q   <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            op_wr_q <= req_write;
            dev_q   <= req_dev;
            reg_q   <= req_reg;
            wdata_q <= req_wdata;
            base_q  <= base_addr;
            rdata_q <= '0;
            tmo_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (xfer_bad) begin
                err_q <= 1'b1;
            end
            if (poll_giveup) begin
                tmo_q <= 1'b1;
            end
            if (xfer_ok && !op_wr_q &&
                ((state_q == ST_DIRECT) || (state_q == ST_GET_DATA))) begin
                rdata_q <= bus_rdata;
            end
        end
    end

    // Output decode
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = base_q;
        bus_reg   = CMD_REG;
        bus_wdata = '0;
        unique case (state_q)
            ST_IDLE, ST_RESPOND: begin
                bus_valid = 1'b0;
            end
            ST_DIRECT: begin
                bus_valid = 1'b1;
                bus_write = op_wr_q;
                bus_addr  = dev_q;
                bus_reg   = reg_q;
                bus_wdata = op_wr_q ? wdata_q : '0;
            end
            ST_WAIT_FREE, ST_WAIT_CMD: begin
                bus_valid = 1'b1;
            end
            ST_PUT_DATA: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_reg   = DATA_REG;
                bus_wdata = wdata_q;
            end
            ST_PUT_CMD: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = cmd_word;
            end
            ST_GET_DATA: begin
                bus_valid = 1'b1;
                bus_reg   = DATA_REG;
            end
            default: begin
                bus_valid = 1'b0;
            end
        endcase
        req_ready   = (state_q == ST_IDLE);
        rsp_done    = (state_q == ST_RESPOND);
        rsp_rdata   = rdata_q;
        rsp_timeout = tmo_q;
        rsp_buserr  = err_q;
    end

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_write) &&
            $stable(bus_addr) && $stable(bus_reg) && $stable(bus_wdata)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !rsp_done));

    // R8
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !(rsp_timeout && rsp_buserr));

    // R2
    base_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (state_q != ST_DIRECT)) |-> (bus_addr == base_q));

    // R6
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUT_CMD && op_wr_q && $past(state_q) != ST_PUT_CMD)
            |-> ($past(state_q) == ST_PUT_DATA));

    // R10
    wr_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && op_wr_q) |-> (rsp_rdata == '0));

endmodule

// File: tb/mgmt_indirect_seq_test.sv
module mgmt_indirect_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  base_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_timeout, rsp_buserr;
    logic [15:0] rsp_rdata;
    logic        bus_valid, bus_write;
    logic [4:0]  bus_addr, bus_reg;
    logic [15:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        bus_err = 1'b0;

    always #2 clk = ~clk;

    mgmt_indirect_seq uut (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
        .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
        .req_reg(req_reg), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .rsp_buserr(rsp_buserr), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    // Device and bus model state
    logic [4:0]  cur_base = '0;
    logic [15:0] dir_val = '0;
    logic [15:0] ind_val = '0;
    int          busy_left = 0;
    int          bpost_cfg = 0;
    int          err_at = 99;
    int          wait_cnt = 0;
    logic        was_pending = 1'b0;
    logic        sv_w;
    logic [4:0]  sv_a, sv_r;
    logic [15:0] sv_d;

    logic        lg_w [64];
    logic [4:0]  lg_a [64];
    logic [4:0]  lg_r [64];
    logic [15:0] lg_d [64];
    int          lg_n = 0;

    logic        e_w [64];
    logic [4:0]  e_a [64];
    logic [4:0]  e_r [64];
    logic [15:0] e_d [64];
    int          e_n;
    logic        e_tmo, e_err;
    logic [15:0] e_rd;

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_done = 1'b0;
            bus_err = 1'b0;
            was_pending = 1'b0;
        end else if (bus_done) begin
            bus_done = 1'b0;
            bus_err = 1'b0;
            was_pending = 1'b0;
            wait_cnt = int'($urandom % 3);
        end else if (bus_valid) begin
            if (was_pending) begin
                // R12: fields held while waiting
                chk("R12", {bus_write, bus_addr, bus_reg, bus_wdata},
                    {sv_w, sv_a, sv_r, sv_d}, "bus fields held");
            end
            sv_w = bus_write; sv_a = bus_addr; sv_r = bus_reg; sv_d = bus_wdata;
            if (wait_cnt != 0) begin
                wait_cnt--;
                was_pending = 1'b1;
            end else begin
                was_pending = 1'b0;
                if (lg_n < 64) begin
                    lg_w[lg_n] = bus_write;
                    lg_a[lg_n] = bus_addr;
                    lg_r[lg_n] = bus_reg;
                    lg_d[lg_n] = bus_write ? bus_wdata : 16'h0000;
                end
                bus_err = (lg_n == err_at);
                lg_n++;
                bus_rdata = 16'($urandom);
                if (cur_base == 5'd0) begin
                    if (!bus_write) bus_rdata = dir_val;
                end else if (bus_reg == 5'd0) begin
                    if (bus_write) begin
                        busy_left = bpost_cfg;
                    end else begin
                        bus_rdata = (busy_left > 0) ? 16'hFFFF : 16'h7FFF;
                        if (busy_left > 0) busy_left--;
                    end
                end else if (!bus_write) begin
                    bus_rdata = ind_val;
                end
                bus_done = 1'b1;
            end
        end else begin
            was_pending = 1'b0;
        end
    end

    function automatic logic [15:0] cmd_of(input logic wr, input logic [4:0] dev,
                                           input logic [4:0] rg);
        // R3 encoding
        return (wr ? 16'h9400 : 16'h9800) | {6'd0, dev, 5'd0} | {11'd0, rg};
    endfunction

    task automatic add_exp(input logic w, input logic [4:0] a, input logic [4:0] r,
                           input logic [15:0] d);
        if (e_n < 64) begin
            e_w[e_n] = w; e_a[e_n] = a; e_r[e_n] = r; e_d[e_n] = d;
        end
        e_n++;
    endtask

    task automatic add_polls(input logic [4:0] b, input int busy, output logic gave_up);
        int n = (busy >= 16) ? 16 : busy + 1;
        for (int i = 0; i < n; i++) add_exp(1'b0, b, 5'd0, 16'h0000);
        gave_up = (busy >= 16);
    endtask

    task automatic build_exp(input logic [4:0] b, input logic wr, input logic [4:0] dev,
                             input logic [4:0] rg, input logic [15:0] wd,
                             input int bpre, input int bpost, input int ea);
        logic gu;
        e_n = 0; e_tmo = 1'b0; e_err = 1'b0; e_rd = 16'h0000;
        if (b == 5'd0) begin
            add_exp(wr, dev, rg, wr ? wd : 16'h0000);
            if (!wr) e_rd = dir_val;
        end else begin
            add_polls(b, bpre, gu);
            if (gu) begin
                e_tmo = 1'b1;
            end else begin
                if (wr) add_exp(1'b1, b, 5'd1, wd);
                add_exp(1'b1, b, 5'd0, cmd_of(wr, dev, rg));
                add_polls(b, bpost, gu);
                if (gu) begin
                    e_tmo = 1'b1;
                end else if (!wr) begin
                    add_exp(1'b0, b, 5'd1, 16'h0000);
                    e_rd = ind_val;
                end
            end
        end
        if (ea < e_n) begin
            e_n = ea + 1; e_err = 1'b1; e_tmo = 1'b0; e_rd = 16'h0000;
        end
    endtask

    task automatic run_req(input logic [4:0] b, input logic wr, input logic [4:0] dev,
                           input logic [4:0] rg, input logic [15:0] wd,
                           input int bpre, input int bpost, input int ea,
                           input logic poke);
        string tag;
        int    lim;
        int    first_bad;
        tag = (b == 5'd0) ? "R1" : (wr ? "R6" : "R7");
        @(negedge clk);
        cur_base = b; busy_left = bpre; bpost_cfg = bpost; err_at = ea; lg_n = 0;
        dir_val = 16'($urandom); ind_val = 16'($urandom);
        build_exp(b, wr, dev, rg, wd, bpre, bpost, ea);
        chk("R9", {31'd0, req_ready}, 32'd1, "ready before request");
        base_addr = b; req_valid = 1'b1; req_write = wr;
        req_dev = dev; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        if (poke) begin
            // R9: second strobe while busy must be ignored
            req_write = ~wr; req_dev = dev ^ 5'h1F; req_reg = rg ^ 5'h0A;
            req_wdata = ~wd;
            @(negedge clk);
        end
        req_valid = 1'b0;
        lim = 0;
        while (!rsp_done && lim < 3000) begin
            @(negedge clk);
            lim++;
        end
        chk(tag, {31'd0, rsp_done}, 32'd1, "completion seen");
        chk("R5", {31'd0, rsp_timeout}, {31'd0, e_tmo}, "timeout flag");
        chk("R8", {31'd0, rsp_buserr}, {31'd0, e_err}, "bus error flag");
        chk(e_err ? "R8" : (e_tmo ? "R5" : "R10"), {16'd0, rsp_rdata},
            {16'd0, e_rd}, "read result");
        @(negedge clk);
        chk("R10", {31'd0, rsp_done}, 32'd0, "done single pulse");
        repeat (2) @(negedge clk);
        chk("R9", {31'd0, bus_valid}, 32'd0, "bus quiet after response");
        chk(tag, lg_n, e_n, "transaction count");
        first_bad = -1;
        for (int i = 0; i < e_n && i < 64 && i < lg_n; i++) begin
            if (first_bad < 0 && {lg_w[i], lg_a[i], lg_r[i], lg_d[i]} !==
                {e_w[i], e_a[i], e_r[i], e_d[i]}) first_bad = i;
        end
        if (first_bad >= 0) begin
            chk("R2 R3 R4", {5'd0, lg_w[first_bad], lg_a[first_bad], lg_r[first_bad],
                lg_d[first_bad]}, {5'd0, e_w[first_bad], e_a[first_bad],
                e_r[first_bad], e_d[first_bad]}, "transaction content");
        end else begin
            chk("R2 R3 R4", 32'd0, 32'd0, "transaction content");
        end
    endtask

    function automatic int pick_busy();
        int r = int'($urandom % 8);
        if (r <= 4) return r;
        if (r == 5) return 15;
        if (r == 6) return 16;
        return 16 + int'($urandom % 4);
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", {31'd0, req_ready}, 32'd1, "ready in reset");
        chk("R11", {31'd0, bus_valid}, 32'd0, "bus idle in reset");
        chk("R11", {31'd0, rsp_done}, 32'd0, "no done in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", {30'd0, req_ready, bus_valid}, 32'd2, "ready after reset");

        // Directed corners
        run_req(5'd0, 1'b1, 5'd7, 5'd3, 16'hBEEF, 0, 0, 99, 1'b0);   // R1 write
        run_req(5'd0, 1'b0, 5'd31, 5'd31, 16'h0, 0, 0, 99, 1'b0);    // R1 read
        run_req(5'd16, 1'b0, 5'd5, 5'd9, 16'h0, 0, 0, 99, 1'b0);     // R7
        run_req(5'd2, 1'b1, 5'd1, 5'd2, 16'h1234, 15, 15, 99, 1'b0); // R4 max ok
        run_req(5'd3, 1'b0, 5'd4, 5'd6, 16'h0, 16, 0, 99, 1'b0);     // R5 pre
        run_req(5'd3, 1'b1, 5'd4, 5'd6, 16'h5A5A, 0, 20, 99, 1'b0);  // R5 post
        run_req(5'd9, 1'b0, 5'd8, 5'd1, 16'h0, 2, 2, 0, 1'b0);       // R8 first
        run_req(5'd9, 1'b1, 5'd8, 5'd1, 16'hCAFE, 1, 1, 3, 1'b0);    // R8 on cmd
        run_req(5'd0, 1'b0, 5'd2, 5'd2, 16'h0, 0, 0, 0, 1'b0);       // R8 direct
        run_req(5'd12, 1'b1, 5'd3, 5'd4, 16'h0F0F, 5, 3, 99, 1'b1);  // R9 poke

        // Random mix
        for (int k = 0; k < 150; k++) begin
            logic [4:0] b;
            int ea;
            b = ($urandom % 2 == 0) ? 5'd0 : 5'(1 + $urandom % 31);
            ea = ($urandom % 6 == 0) ? int'($urandom % 6) : 99;
            run_req(b, 1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    pick_busy(), pick_busy(), ea, ($urandom % 8 == 0) && (b != 0));
        end

        summary();
        $finish;
    end

endmodule